// File: doc/BRIEF.md
# Streaming Grayscale Laplacian Edge Filter

This block takes a raster-ordered stream of packed RGB pixels, one per cycle under a valid/ready handshake, and returns an edge-strength image of the same size. Each incoming pixel is reduced to an 8-bit luma sample with an integer weighted sum. The samples are kept in three on-chip line stores that take turns as the top, middle and bottom line of a 3x3 window. The window goes through a second-derivative kernel, and the clamped result is sent out as a gray pixel with the same value in all three colour bytes.

The output side runs a little more than one line behind the input side. An output pixel is produced once the input pixel below and to the right of it has arrived. The last row of a frame is the bottom border, so it is emitted as zeros as soon as the frame's final input pixel has been taken, with no further input needed. The end of every line and the first pixel of every frame are marked on the output. Back-pressure on the output holds the whole pipeline and loses no pixel. A new frame's input is held off until the previous frame's output is complete.

Top module: `lap_edge_stream`

## Requirements
- R1: Luma is Y = (77*R + 150*G + 29*B) >> 8 in integer arithmetic, where R = in_pixel[23:16], G = in_pixel[15:8] and B = in_pixel[7:0]. Bits [31:24] of the input have no effect.
- R2: For a pixel that is not on the frame border, the raw value is 8 times its own luma minus the sum of the lumas of its eight neighbours.
- R3: A raw value below 0 is output as 0, and a raw value above 255 is output as 255.
- R4: Every pixel in row 0, row IMG_H-1, column 0 or column IMG_W-1 is output as 0.
- R5: Every output word is {8'h00, v, v, v}: bits [31:24] are zero and bytes [23:16], [15:8] and [7:0] all carry the filtered value v.
- R6: Each accepted input pixel yields exactly one output pixel, in raster order. No output pixel of a frame is produced before more than one full line of that frame has been accepted.
- R7: Once the last pixel of a frame has been accepted, all remaining output pixels of that frame, including the whole final row, are delivered with in_valid held low.
- R8: out_last is high exactly on pixels of column IMG_W-1, and out_user is high exactly on the pixel at column 0, row 0.
- R9: While out_valid is high and out_ready is low, out_valid, out_pixel, out_last and out_user stay unchanged on the next cycle.
- R10: Frames sent back to back, each with more lines than there are line stores, are all filtered correctly as the stores rotate.
- R11: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take the input pixel this cycle |
| in_pixel | input | 32 | Packed RGB pixel, R in [23:16], G in [15:8], B in [7:0] |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream takes the output pixel this cycle |
| out_pixel | output | 32 | Gray pixel {8'h00, v, v, v} |
| out_last | output | 1 | Output pixel is the last of its line |
| out_user | output | 1 | Output pixel is the first of its frame |

## Verification
If the line store rotation or a bank choice is wrong, the first interior pixel of the second or third row comes out with a wrong value, so a small frame with a lone bright dot exposes the fault within a few lines. If the input and output pixel counts drift apart, the markers appear on the wrong pixels or the frame does not finish. That shows up at the end of the first line as a misplaced out_last, or at the end of the frame as output pixels that never drain. If the stall hold is broken, a pixel is changed or dropped on the very next cycle of back-pressure, and a scoreboard comparing every output against an independent model reports it on the first mismatch.

// File: rtl/lap_edge_pkg.sv
package lap_edge_pkg;

  localparam int PIX_W  = 32;
  localparam int LUMA_W = 8;
  localparam int SUM_W  = 12;

  // window[row][col], row 0 = top line, col 0 = left column
  typedef logic [2:0][2:0][LUMA_W-1:0] win_t;

  function automatic logic [LUMA_W-1:0] luma_of(input logic [23:0] rgb);
    logic [15:0] acc;
    acc = 16'(rgb[23:16]) * 16'd77 + 16'(rgb[15:8]) * 16'd150 + 16'(rgb[7:0]) * 16'd29;
    return acc[15:8];
  endfunction

  function automatic logic signed [SUM_W-1:0] kernel_of(input win_t w);
    logic signed [SUM_W-1:0] s;
    logic signed [SUM_W-1:0] term;
    s = '0;
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 3; c++) begin
        term = $signed({{(SUM_W-LUMA_W){1'b0}}, w[r][c]});
        if (r == 1 && c == 1) s = s + (term <<< 3);
        else                  s = s - term;
      end
    end
    return s;
  endfunction

  function automatic logic [LUMA_W-1:0] clamp_of(input logic signed [SUM_W-1:0] s);
    if (s < 0)                           return '0;
    else if (s > $signed(SUM_W'(255)))   return 8'hFF;
    else                                 return s[LUMA_W-1:0];
  endfunction

  function automatic logic [PIX_W-1:0] gray_word(input logic [LUMA_W-1:0] v);
    return {8'h00, v, v, v};
  endfunction

endpackage

// File: rtl/lap_luma_unit.sv
module lap_luma_unit
  import lap_edge_pkg::*;
(
  input  logic [23:0]       rgb,
  output logic [LUMA_W-1:0] luma
);
  assign luma = luma_of(rgb);
endmodule

// File: rtl/lap_raster_cnt.sv
module lap_raster_cnt #(
  parameter int IMG_W = 800,
  parameter int IMG_H = 600,
  parameter int XW    = $clog2(IMG_W),
  parameter int YW    = $clog2(IMG_H),
  parameter int CW    = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic [1:0]    bank,
  output logic [CW-1:0] idx,
  output logic          frame_end
);
  logic line_end;
  assign line_end  = (x == XW'(IMG_W - 1));
  assign frame_end = line_end && (y == YW'(IMG_H - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x    <= '0;
      y    <= '0;
      bank <= '0;
      idx  <= '0;
    end else if (step) begin
      if (frame_end) begin
        x    <= '0;
        y    <= '0;
        bank <= '0;
        idx  <= '0;
      end else if (line_end) begin
        x    <= '0;
        y    <= y + 1'b1;
        bank <= (bank == 2'd2) ? 2'd0 : bank + 2'd1;
        idx  <= idx + 1'b1;
      end else begin
        x   <= x + 1'b1;
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lap_line_store.sv
module lap_line_store
  import lap_edge_pkg::*;
#(
  parameter int IMG_W = 800,
  parameter int XW    = $clog2(IMG_W)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [1:0]           wr_bank,
  input  logic [XW-1:0]        wr_col,
  input  logic [LUMA_W-1:0]    wr_data,
  input  logic [2:0][1:0]      rd_bank,   // per window row
  input  logic [2:0][XW-1:0]   rd_col,    // per window column
  output win_t                 win
);
  localparam int NBANK = 3;

  logic [2:0][LUMA_W-1:0] bank_rd [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [LUMA_W-1:0] mem [IMG_W];
    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == 2'(b)) mem[wr_col] <= wr_data;
    end
    assign bank_rd[b] = {mem[rd_col[2]], mem[rd_col[1]], mem[rd_col[0]]};
  end

  always_comb begin
    for (int r = 0; r < 3; r++) begin
      case (rd_bank[r])
        2'd0:    win[r] = bank_rd[0];
        2'd1:    win[r] = bank_rd[1];
        default: win[r] = bank_rd[2];
      endcase
    end
  end
endmodule

// File: rtl/lap_kernel_unit.sv
module lap_kernel_unit
  import lap_edge_pkg::*;
(
  input  win_t              win,
  input  logic              border,
  output logic [LUMA_W-1:0] value
);
  logic signed [SUM_W-1:0] raw;
  assign raw   = kernel_of(win);
  assign value = border ? '0 : clamp_of(raw);
endmodule

// File: rtl/lap_edge_stream.sv
module lap_edge_stream
  import lap_edge_pkg::*;
#(
  parameter int IMG_W = 800,
  parameter int IMG_H = 600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_pixel,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_pixel,
  output logic        out_last,
  output logic        out_user
);
  localparam int TOTAL = IMG_W * IMG_H;
  localparam int XW    = $clog2(IMG_W);
  localparam int YW    = $clog2(IMG_H);
  localparam int CW    = $clog2(TOTAL + 2 * IMG_W + 4);
  localparam int LEAD  = IMG_W + 2;      // inputs needed beyond an output index
  localparam int LIMIT = 2 * IMG_W - 2;  // largest fill that still admits input

  // input side
  logic          in_fire;
  logic [XW-1:0] in_x;
  logic [YW-1:0] in_y_unused;
  logic [1:0]    in_bank;
  logic [CW-1:0] in_idx;
  logic          in_end;
  logic          frame_full;
  logic [LUMA_W-1:0] in_luma;
  logic          unused_pad;

  // output side
  logic          emit;
  logic [XW-1:0] ox;
  logic [YW-1:0] oy;
  logic [1:0]    out_bank;
  logic [CW-1:0] out_idx;
  logic          out_end;
  logic [CW-1:0] in_lin;
  logic [CW-1:0] need;
  logic [CW-1:0] fill;
  logic          stage_free;
  logic          border_px;
  logic [2:0][1:0]    rd_bank;
  logic [2:0][XW-1:0] rd_col;
  win_t               win;
  logic [LUMA_W-1:0]  filt_val;

  assign unused_pad = ^in_pixel[31:24];

  lap_luma_unit u_luma (.rgb(in_pixel[23:0]), .luma(in_luma));

  lap_raster_cnt #(.IMG_W(IMG_W), .IMG_H(IMG_H), .XW(XW), .YW(YW), .CW(CW)) u_in_cnt (
    .clk(clk), .rst_n(rst_n), .step(in_fire),
    .x(in_x), .y(in_y_unused), .bank(in_bank), .idx(in_idx), .frame_end(in_end)
  );

  lap_raster_cnt #(.IMG_W(IMG_W), .IMG_H(IMG_H), .XW(XW), .YW(YW), .CW(CW)) u_out_cnt (
    .clk(clk), .rst_n(rst_n), .step(emit),
    .x(ox), .y(oy), .bank(out_bank), .idx(out_idx), .frame_end(out_end)
  );

  // progress bookkeeping between the two sides
  assign in_lin     = frame_full ? CW'(TOTAL) : in_idx;
  assign fill       = in_lin - out_idx;
  assign need       = (out_idx + CW'(LEAD) > CW'(TOTAL)) ? CW'(TOTAL) : out_idx + CW'(LEAD);
  assign in_ready   = !frame_full && (fill <= CW'(LIMIT));
  assign in_fire    = in_valid && in_ready;
  assign stage_free = !out_valid || out_ready;
  assign emit       = stage_free && (in_lin >= need);

  always_ff @(posedge clk) begin
    if (!rst_n)                 frame_full <= 1'b0;
    else if (in_fire && in_end) frame_full <= 1'b1;
    else if (emit && out_end)   frame_full <= 1'b0;
  end

  // window addressing: middle line is the output row's own bank
  assign rd_bank[1] = out_bank;
  assign rd_bank[0] = (out_bank == 2'd0) ? 2'd2 : out_bank - 2'd1;
  assign rd_bank[2] = (out_bank == 2'd2) ? 2'd0 : out_bank + 2'd1;
  assign rd_col[1]  = ox;
  assign rd_col[0]  = (ox == '0) ? ox : ox - 1'b1;
  assign rd_col[2]  = (ox == XW'(IMG_W - 1)) ? ox : ox + 1'b1;

  assign border_px = (ox == '0) || (ox == XW'(IMG_W - 1)) ||
                     (oy == '0) || (oy == YW'(IMG_H - 1));

  lap_line_store #(.IMG_W(IMG_W), .XW(XW)) u_store (
    .clk(clk), .wr_en(in_fire), .wr_bank(in_bank), .wr_col(in_x), .wr_data(in_luma),
    .rd_bank(rd_bank), .rd_col(rd_col), .win(win)
  );

  lap_kernel_unit u_kernel (.win(win), .border(border_px), .value(filt_val));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
      out_last  <= 1'b0;
      out_user  <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_pixel <= gray_word(filt_val);
      out_last  <= (ox == XW'(IMG_W - 1));
      out_user  <= (ox == '0) && (oy == '0);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lap_edge_chk.sv
module lap_edge_chk #(
  parameter int IMG_W = 800,
  parameter int CW    = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_pixel,
  input logic          out_last,
  input logic          out_user,
  input logic [CW-1:0] fill
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pixel) && $stable(out_last) && $stable(out_user));

  // R5
  gray_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pixel[31:24] == 8'h00 && out_pixel[23:16] == out_pixel[15:8] &&
                  out_pixel[15:8] == out_pixel[7:0]);

  // R4
  corner_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_user |-> out_pixel == 32'h0);

  // R8
  marker_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_user |-> !out_last);

  // R6
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(2 * IMG_W - 1));
endmodule

bind lap_edge_stream lap_edge_chk #(.IMG_W(IMG_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_pixel(out_pixel), .out_last(out_last), .out_user(out_user), .fill(fill)
);

// File: tb/sim_lap_edge_stream.sv
`timescale 1ns/1ps
module sim_lap_edge_stream;
  localparam int BW = 8;
  localparam int BH = 6;
  localparam int NPIX = BW * BH;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_pixel;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_pixel;
  logic        out_last;
  logic        out_user;

  always #4 clk = ~clk;

  lap_edge_stream #(.IMG_W(BW), .IMG_H(BH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel),
    .out_last(out_last), .out_user(out_user)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int tx_total = 0;
  int rx_total = 0;
  int tx_frame = 0;
  int rx_in_frame = 0;
  bit mon_en = 0;
  bit bp_mode = 0;
  bit done = 0;

  logic [33:0] exp_q [$];   // {last, user, word}
  string       tag_q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int luma_ref(input logic [31:0] p);
    int r, g, b;
    r = int'(p[23:16]); g = int'(p[15:8]); b = int'(p[7:0]);
    return (r * 77 + g * 150 + b * 29) / 256;
  endfunction

  function automatic logic [31:0] make_pix(input int pat, input int x, input int y);
    case (pat)
      1: return (x == 3 && y == 2) ? 32'hAA0A141E : 32'h55000000;  // R=10,G=20,B=30
      2: return (x == 4 && y == 3) ? 32'h00FFFFFF : 32'h0;
      3: return ((x + y) % 2 == 1) ? 32'h00FFFFFF : 32'h0;
      4: return 32'h00FFFFFF;
      5: return $urandom & 32'h001F1F1F;
      default: return $urandom;
    endcase
  endfunction

  task automatic send_frame(input int pat, input bit gaps);
    logic [31:0] img [BH][BW];
    int lum [BH][BW];
    for (int y = 0; y < BH; y++)
      for (int x = 0; x < BW; x++) begin
        img[y][x] = make_pix(pat, x, y);
        lum[y][x] = luma_ref(img[y][x]);
      end
    for (int y = 0; y < BH; y++)
      for (int x = 0; x < BW; x++) begin
        int s, v;
        string tg;
        s = 0;
        if (x == 0 || y == 0 || x == BW - 1 || y == BH - 1) begin
          v = 0; tg = "R4";
        end else begin
          s = 9 * lum[y][x];
          for (int dy = -1; dy <= 1; dy++)
            for (int dx = -1; dx <= 1; dx++) s -= lum[y+dy][x+dx];
          if (s < 0) begin v = 0; tg = "R3"; end
          else if (s > 255) begin v = 255; tg = "R3"; end
          else begin v = s; tg = "R1/R2"; end
        end
        exp_q.push_back({(x == BW - 1), (x == 0 && y == 0), 8'h00, v[7:0], v[7:0], v[7:0]});
        tag_q.push_back(tg);
      end
    tx_frame = 0;
    for (int y = 0; y < BH; y++)
      for (int x = 0; x < BW; x++) begin
        bit ok;
        if (gaps) while ($urandom % 4 == 0) begin in_valid = 1'b0; @(negedge clk); end
        in_valid = 1'b1;
        in_pixel = img[y][x];
        ok = 1'b0;
        while (!ok) begin ok = in_ready; @(negedge clk); end
        tx_total++;
        tx_frame++;
      end
    in_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (rx_total != tx_total && n < 4 * NPIX + 100) begin @(negedge clk); n++; end
    chk(rx_total == tx_total, tag, 32'(rx_total), 32'(tx_total));
    chk(exp_q.size() == 0, "R6", 32'(exp_q.size()), 32'h0);
  endtask

  // monitor / scoreboard
  bit          prev_stall = 0;
  logic [31:0] held_pix;
  logic        held_last, held_user;
  always @(negedge clk) begin
    if (mon_en) begin
      if (prev_stall)
        chk(out_valid && out_pixel == held_pix && out_last == held_last && out_user == held_user,
            "R9", out_pixel, held_pix);
      out_ready = bp_mode ? ($urandom % 3 != 0) : 1'b1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 extra output", out_pixel, 32'h0);
        end else begin
          logic [33:0] e;
          string tg;
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          if (rx_in_frame == 0) chk(tx_frame >= BW + 1, "R6", 32'(tx_frame), 32'(BW + 1));
          chk(out_pixel == e[31:0], tg, out_pixel, e[31:0]);
          chk(out_pixel[31:24] == 8'h00 && out_pixel[23:16] == out_pixel[7:0] &&
              out_pixel[15:8] == out_pixel[7:0], "R5", out_pixel, e[31:0]);
          chk(out_last == e[33] && out_user == e[32], "R8", {30'h0, out_last, out_user}, {30'h0, e[33:32]});
        end
        rx_total++;
        rx_in_frame = (rx_in_frame == NPIX - 1) ? 0 : rx_in_frame + 1;
      end
      prev_stall = out_valid && !out_ready;
      held_pix = out_pixel; held_last = out_last; held_user = out_user;
    end
  end

  // watchdog
  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int fails_before;
    rst_n = 1'b0; in_valid = 1'b0; in_pixel = '0; out_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(out_valid == 1'b0, "R11", {31'h0, out_valid}, 32'h0);
    chk(in_ready == 1'b1, "R11", {31'h0, in_ready}, 32'h1);
    mon_en = 1'b1;

    bp_mode = 1'b1;
    send_frame(1, 1'b1); drain("R7");   // coloured dot: luma weights
    send_frame(2, 1'b1); drain("R7");   // white dot: both clamps
    send_frame(3, 1'b0); drain("R7");   // checkerboard
    send_frame(0, 1'b1); drain("R7");   // full random, top byte random

    fails_before = n_fail;
    send_frame(5, 1'b0);                // back to back frames
    send_frame(4, 1'b0);
    send_frame(0, 1'b1);
    drain("R7");
    // R10
    chk(n_fail == fails_before, "R10", 32'(n_fail), 32'(fails_before));

    bp_mode = 1'b0;
    send_frame(5, 1'b0); drain("R7");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule